// File: doc/BRIEF.md
# Address Match Trigger Comparator

This block is the comparison stage of a hardware breakpoint unit. Each trigger supplies an already-legalized control word and a compare address. Every cycle the block tests each trigger against two things: the instruction fetch address and the current data access. The data access is described by its address, its read/write kind and its size. Each match is qualified by the current privilege level.

When any trigger hits, the block raises a breakpoint-exception request in the same cycle, before the fetched instruction or the data access completes. It also reports the index of the trigger that fired. A pipeline uses the request to squash the instruction and to trap to the breakpoint handler.

The control word layout is fixed. Bit 0 arms load watching, bit 1 arms store watching and bit 2 arms execute matching. Bits 3, 4 and 6 allow the trigger in user, supervisor and machine mode; for privilege mode p the bit consulted is 3+p. Bits [11:8] hold the window size code.

Top module: `addr_trigger_match`

## Requirements
- R1: A trigger whose control word has none of bits 3, 4, 6 set, or none of bits 0..2 set, never raises a request.
- R2: A trigger with bit 2 (execute) set hits when `fetch_valid` is high and `fetch_pc` equals its compare value exactly.
- R3: A trigger with bit 0 (load) set hits only on data reads (`data_rd`). A trigger with bit 1 (store) set hits only on data writes (`data_wr`).
- R4: A hit counts only when control bit (3 + `priv`) is set, where `priv` is 0 for user, 1 for supervisor and 3 for machine.
- R5: The data watch window starts at the compare value. Its length comes from size code [11:8]: 1 gives 1 byte, 2 gives 2 bytes, 3 gives 4 bytes, 5 gives 8 bytes, and 0 (any) or any other code gives 8 bytes.
- R6: A data access covers 2^`data_size` bytes from `data_addr`. It hits when any of those bytes falls inside the window, computed without address wrap-around.
- R7: When several triggers hit in one cycle, `bkpt_idx` reports the lowest-numbered one.
- R8: The request is combinational from the inputs. With `fetch_valid` and `data_valid` both low there is no request. While `rst` is high with no valid access, `bkpt_req` is 0.
- R9: `bkpt_req` is 1 exactly when at least one trigger hits, and `bkpt_idx` is meaningful only while `bkpt_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used by the embedded checks |
| rst | input | 1 | Synchronous active-high reset for the checks |
| trig_ctrl | input | NUM_TRIG*12 | Legalized control words, trigger i at [i*12 +: 12] |
| trig_cmp | input | NUM_TRIG*XLEN | Compare addresses, trigger i at [i*XLEN +: XLEN] |
| priv | input | 2 | Current privilege mode (0 U, 1 S, 3 M) |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_pc | input | XLEN | Address of the instruction being fetched |
| data_valid | input | 1 | Data access is valid this cycle |
| data_addr | input | XLEN | Start address of the data access |
| data_rd | input | 1 | Data access is a read |
| data_wr | input | 1 | Data access is a write |
| data_size | input | 2 | log2 of the access length in bytes |
| bkpt_req | output | 1 | Breakpoint exception request |
| bkpt_idx | output | $clog2(NUM_TRIG) | Index of the firing trigger |

## Verification
The embedded checks assume that the control words arrive already legalized, that `priv` never takes the reserved value 2, and that inputs are stable around the sampling clock edge. The bench meets these assumptions in three ways. It only ever builds privilege values 0, 1 and 3. It changes every input on the falling edge. It leaves control bit 5 at zero. Random phases keep compare values and data addresses inside a 64-byte region, so that exact hits, partial window overlaps and simultaneous hits on several triggers all occur often.

// File: rtl/atm_pkg.sv
package atm_pkg;
  localparam int unsigned CTRL_W   = 12;
  localparam int unsigned B_LOAD   = 0;
  localparam int unsigned B_STORE  = 1;
  localparam int unsigned B_EXEC   = 2;
  localparam int unsigned B_PRIV0  = 3;
  localparam int unsigned SZ_LSB   = 8;
  localparam int unsigned SZ_W     = 4;

  // window length in bytes for a size code; any/unsupported -> 8
  function automatic logic [3:0] win_len(input logic [SZ_W-1:0] code);
    case (code)
      4'd1:    win_len = 4'd1;
      4'd2:    win_len = 4'd2;
      4'd3:    win_len = 4'd4;
      4'd5:    win_len = 4'd8;
      default: win_len = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/atm_trig_unit.sv
module atm_trig_unit
  import atm_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [XLEN-1:0]   cmp,
  input  logic [1:0]        priv,
  input  logic              fetch_valid,
  input  logic [XLEN-1:0]   fetch_pc,
  input  logic              data_valid,
  input  logic [XLEN-1:0]   data_addr,
  input  logic              data_rd,
  input  logic              data_wr,
  input  logic [3:0]        acc_len,
  output logic              hit
);
  localparam int unsigned EW = XLEN + 1;

  logic [3:0]  priv_bits;
  logic        priv_ok, armed, exec_hit, data_hit, kind_ok, overlap;
  logic [EW-1:0] a_lo, a_hi, w_lo, w_hi;
  logic        unused_ctrl_bit;

  assign unused_ctrl_bit = ctrl[7];
  assign priv_bits = ctrl[B_PRIV0 +: 4];
  assign priv_ok   = priv_bits[priv];
  assign armed     = (ctrl[B_PRIV0] | ctrl[B_PRIV0+1] | ctrl[B_PRIV0+3]) &&
                     (|ctrl[B_EXEC:B_LOAD]);

  assign a_lo = {1'b0, data_addr};
  assign a_hi = a_lo + {{(EW-4){1'b0}}, acc_len};
  assign w_lo = {1'b0, cmp};
  assign w_hi = w_lo + {{(EW-4){1'b0}}, win_len(ctrl[SZ_LSB +: SZ_W])};
  assign overlap = (a_lo < w_hi) && (w_lo < a_hi);

  assign kind_ok  = (data_rd && ctrl[B_LOAD]) || (data_wr && ctrl[B_STORE]);
  assign exec_hit = fetch_valid && ctrl[B_EXEC] && (fetch_pc == cmp);
  assign data_hit = data_valid && kind_ok && overlap;
  assign hit      = armed && priv_ok && (exec_hit || data_hit);

  // R4: a hit implies the privilege enable for the current mode
  p_priv_qual_r4: assert property (@(posedge clk) disable iff (rst)
    hit |-> ctrl[B_PRIV0 + 32'(priv)]);
  // R1: a hit implies some access kind is armed
  p_kind_armed_r1: assert property (@(posedge clk) disable iff (rst)
    hit |-> (ctrl[B_LOAD] || ctrl[B_STORE] || ctrl[B_EXEC]));
endmodule

// File: rtl/atm_lowest_first.sv
module atm_lowest_first #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_vec[i]) idx = IW'(i);
    end
  end
  assign any = |req_vec;

  // R7: reported index hits and nothing below it does
  p_lowest_wins_r7: assert property (@(posedge clk) disable iff (rst)
    any |-> (req_vec[idx] && ((req_vec & ~({N{1'b1}} << idx)) == '0)));
endmodule

// File: rtl/addr_trigger_match.sv
module addr_trigger_match
  import atm_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 4,
  parameter int unsigned XLEN     = 32,
  localparam int unsigned IW      = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_TRIG*CTRL_W-1:0] trig_ctrl,
  input  logic [NUM_TRIG*XLEN-1:0]   trig_cmp,
  input  logic [1:0]                 priv,
  input  logic                       fetch_valid,
  input  logic [XLEN-1:0]            fetch_pc,
  input  logic                       data_valid,
  input  logic [XLEN-1:0]            data_addr,
  input  logic                       data_rd,
  input  logic                       data_wr,
  input  logic [1:0]                 data_size,
  output logic                       bkpt_req,
  output logic [IW-1:0]              bkpt_idx
);
  logic [NUM_TRIG-1:0] hit_vec;
  logic [3:0]          acc_len;

  assign acc_len = 4'd1 << data_size;

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
    atm_trig_unit #(.XLEN(XLEN)) u_unit (
      .clk        (clk),
      .rst        (rst),
      .ctrl       (trig_ctrl[g*CTRL_W +: CTRL_W]),
      .cmp        (trig_cmp[g*XLEN +: XLEN]),
      .priv       (priv),
      .fetch_valid(fetch_valid),
      .fetch_pc   (fetch_pc),
      .data_valid (data_valid),
      .data_addr  (data_addr),
      .data_rd    (data_rd),
      .data_wr    (data_wr),
      .acc_len    (acc_len),
      .hit        (hit_vec[g])
    );
  end

  atm_lowest_first #(.N(NUM_TRIG)) u_pick (
    .clk    (clk),
    .rst    (rst),
    .req_vec(hit_vec),
    .any    (bkpt_req),
    .idx    (bkpt_idx)
  );

  // R8: no request without a valid fetch or data access
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!fetch_valid && !data_valid) |-> !bkpt_req);
  // R9: reported index names an existing trigger
  p_idx_range_r9: assert property (@(posedge clk) disable iff (rst)
    bkpt_req |-> (32'(bkpt_idx) < NUM_TRIG));
endmodule

// File: tb/addr_trigger_match_test.sv
`timescale 1ns/1ps
module addr_trigger_match_test;
  localparam int NT = 4;
  localparam int XL = 32;
  localparam int CW = 12;
  localparam int IW = $clog2(NT);

  logic clk = 0, rst = 1;
  logic [NT*CW-1:0] ctrl_f = '0;
  logic [NT*XL-1:0] cmp_f = '0;
  logic [1:0] priv = 2'd3;
  logic fv = 0, dv = 0, drd = 0, dwr = 0;
  logic [XL-1:0] fpc = '0, daddr = '0;
  logic [1:0] dsize = '0;
  logic req;
  logic [IW-1:0] idx;
  int vectors = 0, fails = 0;

  always #10 clk = ~clk;

  addr_trigger_match #(.NUM_TRIG(NT), .XLEN(XL)) uut (
    .clk(clk), .rst(rst), .trig_ctrl(ctrl_f), .trig_cmp(cmp_f), .priv(priv),
    .fetch_valid(fv), .fetch_pc(fpc), .data_valid(dv), .data_addr(daddr),
    .data_rd(drd), .data_wr(dwr), .data_size(dsize),
    .bkpt_req(req), .bkpt_idx(idx));

  function automatic logic [CW-1:0] mk(bit ld, bit st, bit ex, bit u, bit s, bit m, int sz);
    logic [CW-1:0] c = '0;
    c[0] = ld; c[1] = st; c[2] = ex; c[3] = u; c[4] = s; c[6] = m;
    c[11:8] = 4'(sz);
    return c;
  endfunction

  task automatic set_trig(int i, logic [CW-1:0] c, logic [XL-1:0] a);
    ctrl_f[i*CW +: CW] = c;
    cmp_f[i*XL +: XL] = a;
  endtask

  task automatic clear_all();
    ctrl_f = '0; cmp_f = '0; fv = 0; dv = 0; drd = 0; dwr = 0;
  endtask

  // reference: -1 when no trigger hits
  function automatic int ref_idx();
    for (int i = 0; i < NT; i++) begin
      logic [CW-1:0] c = ctrl_f[i*CW +: CW];
      longint a = longint'(cmp_f[i*XL +: XL]);
      longint w;
      int n;
      if (!(c[3] || c[4] || c[6])) continue;
      if (c[2:0] == 3'b000) continue;
      if (!c[3 + int'(priv)]) continue;
      if (fv && c[2] && longint'(fpc) == a) return i;
      if (dv && ((drd && c[0]) || (dwr && c[1]))) begin
        case (int'(c[11:8]))
          1: w = 1; 2: w = 2; 3: w = 4; default: w = 8;
        endcase
        n = 1 << dsize;
        for (int b = 0; b < n; b++) begin
          longint p = longint'(daddr) + b;
          if (p >= a && p < a + w) return i;
        end
      end
    end
    return -1;
  endfunction

  task automatic chk(string tag);
    int e;
    #3;
    e = ref_idx();
    vectors++;
    if (req !== (e >= 0) || (e >= 0 && int'(idx) != e)) begin
      fails++;
      $display("FAIL %s: req=%0b idx=%0d expected req=%0b idx=%0d", tag, req, idx, e >= 0, e);
    end
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: run hung, got no end expected end");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R8 reset state
    @(negedge clk); chk("R8 reset");
    @(negedge clk); rst = 0;
    repeat (2) @(negedge clk);

    // R2 execute equality
    clear_all(); set_trig(0, mk(0,0,1,0,0,1,0), 32'h100); priv = 3; fv = 1;
    fpc = 32'h100; chk("R2 exact pc");
    @(negedge clk); fpc = 32'h104; chk("R2 other pc");
    @(negedge clk); fpc = 32'h101; chk("R2 near pc");

    // R4 privilege qualification
    @(negedge clk); fpc = 32'h100; priv = 0; chk("R4 M-only in U");
    @(negedge clk); set_trig(0, mk(0,0,1,1,0,0,0), 32'h100); chk("R4 U-only in U");
    @(negedge clk); priv = 1; chk("R4 U-only in S");
    @(negedge clk); set_trig(0, mk(0,0,1,0,1,0,0), 32'h100); chk("R4 S-only in S");

    // R1 disabled triggers
    @(negedge clk); set_trig(0, mk(0,0,0,1,1,1,0), 32'h100); priv = 3; chk("R1 no kind");
    @(negedge clk); set_trig(0, mk(1,1,1,0,0,0,0), 32'h100); chk("R1 no priv");

    // R3 load/store kinds
    @(negedge clk); clear_all(); set_trig(1, mk(1,0,0,0,0,1,0), 32'h40);
    dv = 1; daddr = 32'h40; dsize = 0; dwr = 1; chk("R3 write vs load-only");
    @(negedge clk); dwr = 0; drd = 1; chk("R3 read vs load-only");
    @(negedge clk); set_trig(1, mk(0,1,0,0,0,1,0), 32'h40); chk("R3 read vs store-only");
    @(negedge clk); drd = 0; dwr = 1; chk("R3 write vs store-only");

    // R5 window sizes
    @(negedge clk); clear_all(); set_trig(0, mk(1,1,0,0,0,1,0), 32'h200);
    dv = 1; drd = 1; dsize = 0; daddr = 32'h207; chk("R5 any size last byte");
    @(negedge clk); daddr = 32'h208; chk("R5 any size past end");
    @(negedge clk); set_trig(0, mk(1,1,0,0,0,1,1), 32'h200); daddr = 32'h201; chk("R5 1B window");
    @(negedge clk); set_trig(0, mk(1,1,0,0,0,1,2), 32'h200); chk("R5 2B window");
    @(negedge clk); set_trig(0, mk(1,1,0,0,0,1,5), 32'h200); daddr = 32'h207; chk("R5 8B window");

    // R6 overlap
    @(negedge clk); set_trig(0, mk(1,1,0,0,0,1,3), 32'h300);
    dsize = 2; daddr = 32'h2FE; chk("R6 partial overlap");
    @(negedge clk); daddr = 32'h2FC; chk("R6 adjacent below");
    @(negedge clk); daddr = 32'h304; chk("R6 adjacent above");
    @(negedge clk); dsize = 3; daddr = 32'h2F9; chk("R6 8B overlap");

    // R7 priority
    @(negedge clk); clear_all();
    set_trig(1, mk(0,0,1,0,0,1,0), 32'h80); set_trig(3, mk(1,0,0,0,0,1,0), 32'h90);
    fv = 1; fpc = 32'h80; dv = 1; drd = 1; daddr = 32'h90; dsize = 0; chk("R7 two hits");
    @(negedge clk); fpc = 32'h84; chk("R7 only upper");

    // R8 valid low
    @(negedge clk); fv = 0; dv = 0; fpc = 32'h80; chk("R8 valid low");

    // R9 random mix
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      for (int i = 0; i < NT; i++) begin
        logic [CW-1:0] c = CW'($urandom);
        c[5] = 0; c[7] = 0;
        set_trig(i, c, XL'($urandom_range(0, 63)));
      end
      priv = ($urandom_range(0, 2) == 2) ? 2'd3 : 2'($urandom_range(0, 1));
      fv = 1'($urandom); dv = 1'($urandom); drd = 1'($urandom); dwr = 1'($urandom);
      fpc = XL'($urandom_range(0, 63)); daddr = XL'($urandom_range(0, 63));
      dsize = 2'($urandom);
      chk("R9 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule